// File: doc/BRIEF.md
# Exception entry and return sequencer

This block decides where the processor goes next when a fault or trap is accepted, when the privileged return instruction executes, and when the block leaves reset. Each cycle it samples a fault code, the current program counter, a return request and the privileged vector base. On an accepted event it produces a redirect pulse with the new program counter and the one after it. It keeps the exception restart address and the privileged register bank state. Privileged mode is carried in bit 0 of the program counter. Every entry vector is odd, so landing on one enters privileged mode.

A fixed group of integer registers has shadow copies. The block does not hold those registers. It drives one select line per architectural register, and the register file uses these lines to pick the shadow copy. The bank is swapped in when an event is taken from user mode. It is swapped out on return when the saved restart address is even. A request to swap into the bank state that is already active is reported on an error pulse, and the bank state is left as it was.

All outputs are registered. An input sampled at one rising edge shows its effect from that edge on.

Top module: `exc_seq_top`

## Requirements
- R1: While rst_n is low: redirect=0, next_pc=0, next_npc=0, restart_addr=0, shadow_en=1, swap_err=0. At the first rising edge with rst_n high, the block redirects to pal_base+0x0001, keeps shadow_en=1 and ignores the other inputs.
- R2: A fault code in the range 1..16, sampled at an edge, makes redirect=1 for one cycle with next_pc = pal_base + offset. The offsets are: 1 reset 0x0001; 2 machine check 0x0401; 3 arithmetic 0x0501; 4 interrupt 0x0101; 5 native data-miss 0x0201; 6 privileged data-miss 0x0281; 7 alignment 0x0301; 8 and 9 data fault/access 0x0381; 10 and 11 instruction miss/fault 0x0181; 12 instruction access 0x0081; 13 illegal opcode 0x0481; 14 FP disabled 0x0581; 15 privileged call 0x2001; 16 integer overflow 0x0501.
- R3: On an accepted code the restart address becomes cur_pc+4 for codes 3, 15 and 16. For every other code it becomes cur_pc.
- R4: Code 4 sampled while cur_pc[0]=1 leaves restart_addr unchanged.
- R5: An event taken with cur_pc[0]=0 sets shadow_en to 1. An event taken with cur_pc[0]=1 leaves shadow_en as it is.
- R6: On every redirect, next_npc equals next_pc+4.
- R7: A return request with cur_pc[0]=0 and no fault code is handled as code 13. It vectors to pal_base+0x0481, sets restart_addr=cur_pc and swaps the bank in.
- R8: A return request with cur_pc[0]=1 and no fault code redirects to the current restart_addr. It clears shadow_en only when restart_addr[0]=0.
- R9: When a swap-in is asked for while shadow_en=1, or a swap-out while shadow_en=0, swap_err is 1 for one cycle and shadow_en keeps its value.
- R10: A fault code of 1..16 takes priority over a return request in the same cycle. Codes 0 and 17..31 with no return request cause no redirect and change none of next_pc, restart_addr or shadow_en.
- R11: bank_sel[i] equals shadow_en for i = 8..14 and i = 25. It is 0 for all other i (map 0x02007F00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_code | input | 5 | Event code, 0 = none |
| ret_req | input | 1 | Privileged return instruction executing |
| cur_pc | input | AW | Current program counter, bit 0 = privileged |
| pal_base | input | AW | Base of the privileged vector area |
| redirect | output | 1 | One-cycle pulse: take next_pc |
| next_pc | output | AW | Redirect target |
| next_npc | output | AW | Target plus one instruction |
| restart_addr | output | AW | Saved exception restart address |
| shadow_en | output | 1 | Shadow register bank active |
| bank_sel | output | NREGS | Per-register shadow select |
| swap_err | output | 1 | Swap into the already active bank state |

## Verification
The hardest states to reach are the two swap errors. A swap-in error needs an event from user mode while the bank is already in. A swap-out error needs a privileged return with an even restart address while the bank is already out. Neither happens in a normal entry/return pairing. The directed sequence gets there on purpose. It takes a privileged-mode fault so that the restart address is odd and the bank stays in through a return. It then presents a user-mode fault, and then returns twice from privileged mode. A seeded random sweep follows, which mixes illegal codes, odd and even program counters and returns, and compares every output against the bench model on every cycle.

// File: rtl/exc_seq_pkg.sv
`timescale 1ns/1ps
package exc_seq_pkg;

   localparam int FCODE_W = 5;
   localparam int VOFF_W  = 16;

   typedef enum logic [FCODE_W-1:0] {
      FC_NONE    = 5'd0,
      FC_RESET   = 5'd1,
      FC_MCHK    = 5'd2,
      FC_ARITH   = 5'd3,
      FC_INTR    = 5'd4,
      FC_DMISS_N = 5'd5,
      FC_DMISS_P = 5'd6,
      FC_ALIGN   = 5'd7,
      FC_DFAULT  = 5'd8,
      FC_DACV    = 5'd9,
      FC_IMISS   = 5'd10,
      FC_IFAULT  = 5'd11,
      FC_IACV    = 5'd12,
      FC_OPC     = 5'd13,
      FC_FPDIS   = 5'd14,
      FC_PCALL   = 5'd15,
      FC_IOVF    = 5'd16
   } fcode_e;

   localparam logic [FCODE_W-1:0] FC_MAX = 5'd16;

   function automatic logic code_known(input logic [FCODE_W-1:0] c);
      return (c != 5'd0) && (c <= FC_MAX);
   endfunction

   function automatic logic is_trap(input logic [FCODE_W-1:0] c);
      return (c == FC_ARITH) || (c == FC_PCALL) || (c == FC_IOVF);
   endfunction

   function automatic logic [VOFF_W-1:0] vec_offset(input logic [FCODE_W-1:0] c);
      logic [VOFF_W-1:0] o;
      case (c)
         FC_RESET:              o = 16'h0001;
         FC_IACV:               o = 16'h0081;
         FC_INTR:               o = 16'h0101;
         FC_IMISS, FC_IFAULT:   o = 16'h0181;
         FC_DMISS_N:            o = 16'h0201;
         FC_DMISS_P:            o = 16'h0281;
         FC_ALIGN:              o = 16'h0301;
         FC_DFAULT, FC_DACV:    o = 16'h0381;
         FC_MCHK:               o = 16'h0401;
         FC_OPC:                o = 16'h0481;
         FC_ARITH, FC_IOVF:     o = 16'h0501;
         FC_FPDIS:              o = 16'h0581;
         FC_PCALL:              o = 16'h2001;
         default:               o = 16'h0000;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/exc_vec_sel.sv
`timescale 1ns/1ps
module exc_vec_sel
   import exc_seq_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [FCODE_W-1:0] code,
   input  logic [AW-1:0]      base,
   output logic [AW-1:0]      target
);
   // vector = privileged base + fixed per-code offset
   assign target = base + AW'(vec_offset(code));
endmodule

// File: rtl/exc_restart_calc.sv
`timescale 1ns/1ps
module exc_restart_calc
   import exc_seq_pkg::*;
#(
   parameter int AW      = 32,
   parameter int PC_STEP = 4
) (
   input  logic [FCODE_W-1:0] code,
   input  logic [AW-1:0]      cur_pc,
   input  logic               take,
   output logic               wr_en,
   output logic [AW-1:0]      wr_val
);
   localparam logic [AW-1:0] STEP_V = AW'(PC_STEP);

   logic intr_in_priv;

   // an interrupt nested inside privileged code keeps the earlier restart point
   assign intr_in_priv = (code == FC_INTR) && cur_pc[0];
   assign wr_en        = take && !intr_in_priv;
   // traps resume after the instruction, faults re-execute it
   assign wr_val       = is_trap(code) ? (cur_pc + STEP_V) : cur_pc;
endmodule

// File: rtl/exc_bank_ctl.sv
`timescale 1ns/1ps
module exc_bank_ctl #(
   parameter bit ERR_STICKY = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic swap_in,
   input  logic swap_out,
   output logic shadow_q,
   output logic err_q
);
   logic bad_req;

   assign bad_req = (swap_in && shadow_q) || (swap_out && !shadow_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= 1'b1;
      end else if (swap_in && !shadow_q) begin
         shadow_q <= 1'b1;
      end else if (swap_out && shadow_q) begin
         shadow_q <= 1'b0;
      end
   end

   generate
      if (ERR_STICKY) begin : g_err_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= err_q | bad_req;
         end
      end else begin : g_err_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= bad_req;
         end
      end
   endgenerate
endmodule

// File: rtl/exc_seq_top.sv
`timescale 1ns/1ps
module exc_seq_top
   import exc_seq_pkg::*;
#(
   parameter int               AW         = 32,
   parameter int               PC_STEP    = 4,
   parameter int               NREGS      = 32,
   parameter logic [NREGS-1:0] SHADOW_MAP = 32'h0200_7F00,
   parameter bit               ERR_STICKY = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [4:0]         fault_code,
   input  logic               ret_req,
   input  logic [AW-1:0]      cur_pc,
   input  logic [AW-1:0]      pal_base,
   output logic               redirect,
   output logic [AW-1:0]      next_pc,
   output logic [AW-1:0]      next_npc,
   output logic [AW-1:0]      restart_addr,
   output logic               shadow_en,
   output logic [NREGS-1:0]   bank_sel,
   output logic               swap_err
);
   localparam logic [AW-1:0] STEP_V = AW'(PC_STEP);

   generate
      if (AW < VOFF_W) begin : g_chk_aw
         $error("exc_seq_top: AW too narrow for the vector offsets");
      end
      if (NREGS < 1 || NREGS > 64) begin : g_chk_nregs
         $error("exc_seq_top: NREGS out of range");
      end
      if (PC_STEP < 2) begin : g_chk_step
         $error("exc_seq_top: PC_STEP must keep bit 0 free");
      end
   endgenerate

   logic                boot_q;
   logic                priv;
   logic                fault_ok;
   logic                ret_ok;
   logic                take_entry;
   logic                take_ret;
   logic [FCODE_W-1:0]  eff_code;
   logic [AW-1:0]       vec_tgt;
   logic                rs_wr_en;
   logic [AW-1:0]       rs_wr_val;
   logic                swap_in;
   logic                swap_out;
   logic                shadow_q;

   assign priv       = cur_pc[0];
   assign fault_ok   = code_known(fault_code);
   assign ret_ok     = ret_req && !fault_ok;
   assign take_entry = !boot_q && (fault_ok || (ret_ok && !priv));
   assign take_ret   = !boot_q && ret_ok && priv;

   always_comb begin
      if (boot_q)        eff_code = FC_RESET;
      else if (fault_ok) eff_code = fault_code;
      else               eff_code = FC_OPC;
   end

   exc_vec_sel #(.AW(AW)) u_vec (
      .code   (eff_code),
      .base   (pal_base),
      .target (vec_tgt)
   );

   exc_restart_calc #(.AW(AW), .PC_STEP(PC_STEP)) u_rs (
      .code   (eff_code),
      .cur_pc (cur_pc),
      .take   (take_entry),
      .wr_en  (rs_wr_en),
      .wr_val (rs_wr_val)
   );

   assign swap_in  = take_entry && !priv;
   assign swap_out = take_ret && !restart_addr[0];

   exc_bank_ctl #(.ERR_STICKY(ERR_STICKY)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .swap_in  (swap_in),
      .swap_out (swap_out),
      .shadow_q (shadow_q),
      .err_q    (swap_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_q       <= 1'b1;
         redirect     <= 1'b0;
         next_pc      <= '0;
         next_npc     <= '0;
         restart_addr <= '0;
      end else begin
         boot_q   <= 1'b0;
         redirect <= boot_q || take_entry || take_ret;
         if (boot_q || take_entry) begin
            next_pc  <= vec_tgt;
            next_npc <= vec_tgt + STEP_V;
         end else if (take_ret) begin
            next_pc  <= restart_addr;
            next_npc <= restart_addr + STEP_V;
         end
         if (rs_wr_en) restart_addr <= rs_wr_val;
      end
   end

   assign shadow_en = shadow_q;

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_bank
         if (SHADOW_MAP[i]) begin : g_on
            assign bank_sel[i] = shadow_q;
         end else begin : g_off
            assign bank_sel[i] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/exc_seq_chk.sv
`timescale 1ns/1ps
module exc_seq_chk #(
   parameter int AW      = 32,
   parameter int PC_STEP = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [4:0]    fault_code,
   input logic          ret_req,
   input logic [AW-1:0] cur_pc,
   input logic [AW-1:0] pal_base,
   input logic          redirect,
   input logic [AW-1:0] next_pc,
   input logic [AW-1:0] next_npc,
   input logic [AW-1:0] restart_addr,
   input logic          shadow_en,
   input logic          swap_err
);
   logic first_q;
   logic known;
   logic trap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) first_q <= 1'b1;
      else        first_q <= 1'b0;
   end

   assign known = (fault_code != 5'd0) && (fault_code <= 5'd16);
   assign trap  = (fault_code == 5'd3) || (fault_code == 5'd15) || (fault_code == 5'd16);

   assert_boot_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
      first_q |=> redirect && (next_pc == $past(pal_base) + AW'(1)) && shadow_en);

   assert_entry_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!first_q && known) |=> redirect && ((next_pc - $past(pal_base)) < AW'(16'h2002))
                              && ((next_pc - $past(pal_base)) & AW'(1)) == AW'(1));

   assert_trap_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!first_q && trap) |=> restart_addr == $past(cur_pc) + AW'(PC_STEP));

   assert_intr_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!first_q && fault_code == 5'd4 && cur_pc[0]) |=> $stable(restart_addr));

   assert_user_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!first_q && known && !cur_pc[0]) |=> shadow_en);

   assert_npc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      redirect |-> next_npc == next_pc + AW'(PC_STEP));

   assert_user_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!first_q && !known && ret_req && !cur_pc[0]) |=> redirect && shadow_en
                              && restart_addr == $past(cur_pc));

   assert_priv_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!first_q && !known && ret_req && cur_pc[0]) |=> redirect
                              && next_pc == $past(restart_addr));

   assert_swap_in_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!first_q && known && !cur_pc[0] && shadow_en) |=> swap_err && shadow_en);

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!first_q && !known && !ret_req) |=> !redirect && $stable(restart_addr)
                              && $stable(shadow_en) && $stable(next_pc));
endmodule

bind exc_seq_top exc_seq_chk #(.AW(AW), .PC_STEP(PC_STEP)) u_exc_seq_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fault_code   (fault_code),
   .ret_req      (ret_req),
   .cur_pc       (cur_pc),
   .pal_base     (pal_base),
   .redirect     (redirect),
   .next_pc      (next_pc),
   .next_npc     (next_npc),
   .restart_addr (restart_addr),
   .shadow_en    (shadow_en),
   .swap_err     (swap_err)
);

// File: tb/test_exc_seq_top.sv
`timescale 1ns/1ps
module test_exc_seq_top;
   localparam logic [31:0] PB  = 32'h0010_0000;
   localparam logic [31:0] MAP = 32'h0200_7F00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  fault_code = '0;
   logic        ret_req = 1'b0;
   logic [31:0] cur_pc = '0;
   logic [31:0] pal_base = PB;
   logic        redirect;
   logic [31:0] next_pc;
   logic [31:0] next_npc;
   logic [31:0] restart_addr;
   logic        shadow_en;
   logic [31:0] bank_sel;
   logic        swap_err;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic        m_boot = 1'b1;
   logic        m_redir = 1'b0;
   logic [31:0] m_npc = '0;
   logic [31:0] m_nnpc = '0;
   logic [31:0] m_exc = '0;
   logic        m_shadow = 1'b1;
   logic        m_err = 1'b0;

   always #2.5 clk = ~clk;

   exc_seq_top i_exc_seq_top (
      .clk(clk), .rst_n(rst_n), .fault_code(fault_code), .ret_req(ret_req),
      .cur_pc(cur_pc), .pal_base(pal_base), .redirect(redirect),
      .next_pc(next_pc), .next_npc(next_npc), .restart_addr(restart_addr),
      .shadow_en(shadow_en), .bank_sel(bank_sel), .swap_err(swap_err)
   );

   function automatic logic [31:0] voff(input int c);
      case (c)
         1: return 32'h0001;   2: return 32'h0401;   3: return 32'h0501;
         4: return 32'h0101;   5: return 32'h0201;   6: return 32'h0281;
         7: return 32'h0301;   8: return 32'h0381;   9: return 32'h0381;
         10: return 32'h0181;  11: return 32'h0181;  12: return 32'h0081;
         13: return 32'h0481;  14: return 32'h0581;  15: return 32'h2001;
         16: return 32'h0501;
         default: return 32'h0;
      endcase
   endfunction

   task automatic model_next(input int c, input logic [31:0] pc, input logic r);
      bit ok = (c >= 1 && c <= 16);
      int cc;
      m_err = 1'b0;
      m_redir = 1'b0;
      if (m_boot) begin
         m_boot = 1'b0;
         m_redir = 1'b1;
         m_npc = pal_base + 32'h1;
      end else if (ok || (r && !pc[0])) begin
         cc = ok ? c : 13;
         m_redir = 1'b1;
         m_npc = pal_base + voff(cc);
         if (!(cc == 4 && pc[0]))
            m_exc = (cc == 3 || cc == 15 || cc == 16) ? pc + 32'd4 : pc;
         if (!pc[0]) begin
            if (m_shadow) m_err = 1'b1;
            else          m_shadow = 1'b1;
         end
      end else if (r) begin
         m_redir = 1'b1;
         m_npc = m_exc;
         if (!m_exc[0]) begin
            if (!m_shadow) m_err = 1'b1;
            else           m_shadow = 1'b0;
         end
      end
      if (m_redir) m_nnpc = m_npc + 32'd4;
   endtask

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(input string tag);
      chk(tag, "redirect", {31'd0, redirect}, {31'd0, m_redir});
      chk(tag, "next_pc", next_pc, m_npc);
      chk("R6", "next_npc", next_npc, m_nnpc);
      chk(tag, "restart_addr", restart_addr, m_exc);
      chk(tag, "shadow_en", {31'd0, shadow_en}, {31'd0, m_shadow});
      chk("R11", "bank_sel", bank_sel, m_shadow ? MAP : 32'h0);
      chk("R9", "swap_err", {31'd0, swap_err}, {31'd0, m_err});
   endtask

   task automatic step(input int c, input logic [31:0] pc, input logic r, input string tag);
      fault_code = 5'(c);
      cur_pc = pc;
      ret_req = r;
      model_next(c, pc, r);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare("R1");                                  // reset state
      rst_n = 1'b1;
      step(0, 32'h0, 1'b0, "R1");                     // boot vector
      step(0, PB + 32'h5, 1'b1, "R8");                // priv return, even restart -> bank out
      step(0, 32'h0, 1'b0, "R10");
      step(17, 32'h100, 1'b0, "R10");                 // undefined codes ignored
      step(31, 32'h200, 1'b0, "R10");
      for (int c = 1; c <= 16; c++) begin             // every vector from user mode
         step(c, 32'h1000 + 32'(c) * 32'h10, 1'b0, "R2");
         step(0, PB + voff(c), 1'b1, "R3");           // return uses saved address
      end
      step(5, 32'h5000, 1'b0, "R5");                  // user entry
      step(4, PB + 32'h205, 1'b0, "R4");              // nested interrupt keeps restart
      step(0, PB + 32'h105, 1'b1, "R8");
      step(8, 32'h6000, 1'b0, "R5");                  // user entry, bank in
      step(7, PB + 32'h9, 1'b0, "R5");                // priv fault: odd restart, no swap
      step(0, PB + 32'h301, 1'b1, "R8");              // odd restart: bank stays in
      step(0, PB + 32'h9, 1'b1, "R8");
      step(2, 32'h6100, 1'b0, "R9");                  // swap-in while in -> error
      step(0, PB + 32'h401, 1'b1, "R8");              // bank out
      step(0, PB + 32'h11, 1'b1, "R9");               // swap-out while out -> error
      step(0, 32'h7000, 1'b1, "R7");                  // return from user -> opcode fault
      step(0, PB + 32'h481, 1'b1, "R8");
      step(10, 32'h8000, 1'b1, "R10");                // fault beats return
      step(0, PB + 32'h181, 1'b1, "R8");
      for (int k = 0; k < 400; k++) begin
         int unsigned rv = $urandom;
         int c = (rv[3:0] < 4'd6) ? int'(rv[8:4]) : 0;
         logic [31:0] pc = {$urandom} & 32'h00FF_FFFD;
         step(c, pc, rv[10], "R2/R3 sweep");
      end
      summary();
      $finish;
   end

   initial begin
      #1000000;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
   end
endmodule